// File: doc/BRIEF.md
# Trap Routing and Privileged State Unit

This block sits next to a processor core that runs in machine, supervisor or user privilege. When the core raises an exception or an interrupt, the block picks the mode that will handle it. The choice comes from two delegation masks, one for exceptions and one for interrupts, and from the current privilege. Only the chosen mode's cause, exception-PC and trap-value registers are loaded. The block updates that mode's status bits and sends the core to that mode's vector. Neither mode's registers are ever copied into the other's.

On a return request the block sends the core back to the address held in the selected mode's exception-PC register. It restores the saved privilege and interrupt enable. Each mode also owns a scratch register. Hardware never loads or swaps a scratch register; only software writes change it. The block holds no general-purpose register state, so trap entry and return leave the shared register file alone.

Top module: `trap_route_unit`

## Requirements
- R1: After reset, cur_priv is machine (2'b11) and redirect_valid is 0. All cause, exception-PC, trap-value, vector, status and delegation registers read as zero. Privilege encodings: user 2'b00, supervisor 2'b01, machine 2'b11.
- R2: A trap goes to supervisor only when cur_priv is not machine and the mask bit indexed by trap_code is set. The interrupt mask is used when trap_irq is 1, the exception mask otherwise. Every other trap goes to machine.
- R3: A trap writes the cause, exception-PC and trap-value registers of the target mode only. The other mode's copies keep their values. A cause register changes only through a trap into its own mode or a CSR write.
- R4: The cause value has trap_irq in bit XLEN-1, trap_code in the low CODE_W bits, and zeros between them.
- R5: On a trap, the target's exception-PC register takes trap_pc and its trap-value register takes trap_val.
- R6: On the cycle after a trap request, redirect_valid is 1 and redirect_pc is the target's vector register with bits 1:0 cleared. cur_priv then equals the target mode.
- R7: On trap entry the target's status word {pp[1:0], pie, ie} in bits 3:0 becomes {previous cur_priv, old ie, 0}.
- R8: ret_req with ret_sel_m=1 selects the machine registers, and ret_sel_m=0 selects the supervisor registers. On the next cycle redirect_valid is 1, redirect_pc is the selected exception-PC, and cur_priv is the saved pp. In the selected status word, ie takes pie, pie becomes 1 and pp becomes user.
- R9: When trap_req and ret_req are both high, the trap is taken and the return is ignored.
- R10: The scratch registers have no reset value. They change only through CSR writes; traps and returns leave them alone.
- R11: CSR map on csr_addr. Machine: 0 cause, 1 epc, 2 tval, 3 scratch, 4 vector, 5 status, 6 exception mask, 7 interrupt mask. Supervisor: 8 cause, 9 epc, 10 tval, 11 scratch, 12 vector, 13 status. csr_rdata is combinational from csr_addr, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Exception or interrupt is being taken |
| trap_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_code | input | CODE_W | Cause code, also the delegation mask index |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_val | input | XLEN | Trap-specific value |
| ret_req | input | 1 | Trap-return request |
| ret_sel_m | input | 1 | 1 for machine return, 0 for supervisor return |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 4 | CSR select (see R11) |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| redirect_valid | output | 1 | PC redirect strobe |
| redirect_pc | output | XLEN | New PC |
| cur_priv | output | 2 | Current privilege |

## Verification
Exceptions and interrupts are raised from each privilege, with their code bits set and clear in the masks. This separates which of the three delegation conditions makes a wrong choice. After each trap, both modes' cause, exception-PC and status registers are read back, so a write to the wrong mode or a missed save is visible. A trap and a return are raised in the same cycle to expose the priority order. A code at the top of the mask range checks the index decode, and the scratch values are checked last to catch any hardware write to them.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam logic [2:0] BK_CAUSE   = 3'd0;
   localparam logic [2:0] BK_EPC     = 3'd1;
   localparam logic [2:0] BK_TVAL    = 3'd2;
   localparam logic [2:0] BK_SCRATCH = 3'd3;
   localparam logic [2:0] BK_TVEC    = 3'd4;
   localparam logic [2:0] BK_STATUS  = 3'd5;

   localparam logic [3:0] AD_EDELEG = 4'd6;
   localparam logic [3:0] AD_IDELEG = 4'd7;
endpackage

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
   import trap_route_pkg::*;
#(
   parameter int CODE_W    = 5,
   parameter bit S_MODE_EN = 1'b1,
   localparam int NCODE    = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_we,
   input  logic              in_we,
   input  logic [NCODE-1:0]  wdata,
   input  logic              is_irq,
   input  logic [CODE_W-1:0] code,
   input  logic [1:0]        cur_priv,
   output logic              to_s,
   output logic [NCODE-1:0]  ex_mask,
   output logic [NCODE-1:0]  in_mask
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_mask <= '0;
         in_mask <= '0;
      end else begin
         if (ex_we) ex_mask <= wdata;
         if (in_we) in_mask <= wdata;
      end
   end

   generate
      if (S_MODE_EN) begin : g_route
         logic bit_set;
         assign bit_set = is_irq ? in_mask[code] : ex_mask[code];
         assign to_s    = bit_set && (cur_priv != PRIV_M);
      end else begin : g_mach_only
         assign to_s = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trap_mode_bank.sv
module trap_mode_bank
   import trap_route_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              leave,
   input  logic              is_irq,
   input  logic [CODE_W-1:0] code,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   val,
   input  logic [1:0]        from_priv,
   input  logic              wr_en,
   input  logic [2:0]        idx,
   input  logic [XLEN-1:0]   wdata,
   output logic [XLEN-1:0]   rdata,
   output logic [XLEN-1:0]   epc_o,
   output logic [XLEN-1:0]   vec_o,
   output logic [1:0]        pp_o
);
   localparam int PAD_W = XLEN - 1 - CODE_W;

   logic [XLEN-1:0] cause, epc, tval, scratch, tvec;
   logic            ie, pie;
   logic [1:0]      pp;
   logic [XLEN-1:0] cause_val;

   assign cause_val = {is_irq, {PAD_W{1'b0}}, code};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         epc   <= '0;
         tval  <= '0;
         tvec  <= '0;
         ie    <= 1'b0;
         pie   <= 1'b0;
         pp    <= PRIV_U;
      end else if (take) begin
         cause <= cause_val;
         epc   <= pc;
         tval  <= val;
         pp    <= from_priv;
         pie   <= ie;
         ie    <= 1'b0;
         if (wr_en && idx == BK_TVEC) tvec <= wdata;
      end else begin
         if (leave) begin
            ie  <= pie;
            pie <= 1'b1;
            pp  <= PRIV_U;
         end
         if (wr_en) begin
            case (idx)
               BK_CAUSE: cause <= wdata;
               BK_EPC:   epc   <= wdata;
               BK_TVAL:  tval  <= wdata;
               BK_TVEC:  tvec  <= wdata;
               BK_STATUS: if (!leave) begin
                  ie  <= wdata[0];
                  pie <= wdata[1];
                  pp  <= wdata[3:2];
               end
               default: ;
            endcase
         end
      end
   end

   // no reset: only software gives the scratch register a value
   always_ff @(posedge clk) begin
      if (wr_en && idx == BK_SCRATCH) scratch <= wdata;
   end

   always_comb begin
      rdata = '0;
      case (idx)
         BK_CAUSE:   rdata = cause;
         BK_EPC:     rdata = epc;
         BK_TVAL:    rdata = tval;
         BK_SCRATCH: rdata = scratch;
         BK_TVEC:    rdata = tvec;
         BK_STATUS:  rdata[3:0] = {pp, pie, ie};
         default:    rdata = '0;
      endcase
   end

   assign epc_o = epc;
   assign vec_o = {tvec[XLEN-1:2], 2'b00};
   assign pp_o  = pp;

   assert_cause_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !(wr_en && idx == BK_CAUSE)) |=> $stable(cause));

   assert_scratch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == BK_SCRATCH) |=> $stable(scratch));

   assert_entry_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!ie && pp == $past(from_priv)));

   assert_leave_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (leave && !take) |=> (pie && pp == PRIV_U));
endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
   import trap_route_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CODE_W    = 5,
   parameter bit S_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_req,
   input  logic              trap_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic [XLEN-1:0]   trap_val,
   input  logic              ret_req,
   input  logic              ret_sel_m,
   input  logic              csr_we,
   input  logic [3:0]        csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic [1:0]        cur_priv
);
   localparam int NCODE = 1 << CODE_W;

   generate
      if (CODE_W < 1 || XLEN < NCODE || XLEN < CODE_W + 2) begin : g_bad_cfg
         $error("trap_route_unit: XLEN must hold 2**CODE_W mask bits and the cause code");
      end
   endgenerate

   logic              to_s;
   logic              take_m, take_s, leave_m, leave_s;
   logic              m_we, s_we, ex_we, in_we;
   logic [NCODE-1:0]  ex_mask, in_mask;
   logic [XLEN-1:0]   m_rdata, s_rdata, m_epc, s_epc, m_vec, s_vec;
   logic [1:0]        m_pp, s_pp;

   assign take_s  = trap_req & to_s;
   assign take_m  = trap_req & ~to_s;
   assign leave_m = ret_req & ~trap_req & ret_sel_m;
   assign leave_s = ret_req & ~trap_req & ~ret_sel_m;

   assign m_we  = csr_we & ~csr_addr[3] & (csr_addr[2:0] <= BK_STATUS);
   assign s_we  = csr_we & csr_addr[3];
   assign ex_we = csr_we & (csr_addr == AD_EDELEG);
   assign in_we = csr_we & (csr_addr == AD_IDELEG);

   trap_deleg_sel #(.CODE_W(CODE_W), .S_MODE_EN(S_MODE_EN)) deleg_i (
      .clk(clk), .rst_n(rst_n), .ex_we(ex_we), .in_we(in_we),
      .wdata(csr_wdata[NCODE-1:0]), .is_irq(trap_irq), .code(trap_code),
      .cur_priv(cur_priv), .to_s(to_s), .ex_mask(ex_mask), .in_mask(in_mask)
   );

   trap_mode_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) mbank_i (
      .clk(clk), .rst_n(rst_n), .take(take_m), .leave(leave_m),
      .is_irq(trap_irq), .code(trap_code), .pc(trap_pc), .val(trap_val),
      .from_priv(cur_priv), .wr_en(m_we), .idx(csr_addr[2:0]),
      .wdata(csr_wdata), .rdata(m_rdata), .epc_o(m_epc), .vec_o(m_vec),
      .pp_o(m_pp)
   );

   trap_mode_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) sbank_i (
      .clk(clk), .rst_n(rst_n), .take(take_s), .leave(leave_s),
      .is_irq(trap_irq), .code(trap_code), .pc(trap_pc), .val(trap_val),
      .from_priv(cur_priv), .wr_en(s_we), .idx(csr_addr[2:0]),
      .wdata(csr_wdata), .rdata(s_rdata), .epc_o(s_epc), .vec_o(s_vec),
      .pp_o(s_pp)
   );

   always_comb begin
      csr_rdata = '0;
      if (csr_addr[3])                 csr_rdata = s_rdata;
      else if (csr_addr == AD_EDELEG)  csr_rdata[NCODE-1:0] = ex_mask;
      else if (csr_addr == AD_IDELEG)  csr_rdata[NCODE-1:0] = in_mask;
      else                             csr_rdata = m_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_priv       <= PRIV_M;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else if (trap_req) begin
         redirect_valid <= 1'b1;
         redirect_pc    <= to_s ? s_vec : m_vec;
         cur_priv       <= to_s ? PRIV_S : PRIV_M;
      end else if (ret_req) begin
         redirect_valid <= 1'b1;
         redirect_pc    <= ret_sel_m ? m_epc : s_epc;
         cur_priv       <= ret_sel_m ? m_pp : s_pp;
      end else begin
         redirect_valid <= 1'b0;
      end
   end

   assert_redirect_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (redirect_valid && redirect_pc[1:0] == 2'b00));

   assert_machine_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && cur_priv == PRIV_M) |=> cur_priv == PRIV_M);

   assert_trap_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && ret_req) |=> cur_priv == ($past(to_s) ? PRIV_S : PRIV_M));

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_req || ret_req) |=> !redirect_valid);
endmodule

// File: tb/trap_route_unit_tb_top.sv
module trap_route_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0, trap_irq = 1'b0;
   logic [4:0]  trap_code = '0;
   logic [31:0] trap_pc = '0, trap_val = '0;
   logic        ret_req = 1'b0, ret_sel_m = 1'b0;
   logic        csr_we = 1'b0;
   logic [3:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic [1:0]  cur_priv;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [31:0] pc;
      logic [1:0]  priv;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   trap_route_unit dut_i (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
      .trap_code(trap_code), .trap_pc(trap_pc), .trap_val(trap_val),
      .ret_req(ret_req), .ret_sel_m(ret_sel_m), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .cur_priv(cur_priv)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare each redirect against the scoreboard
   always @(negedge clk) begin
      if (rst_n && redirect_valid) begin
         if (sb.size() == 0) begin
            chk("R6 unexpected redirect", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " pc"}, redirect_pc, e.pc);
            chk({e.tag, " priv"}, {30'd0, cur_priv}, {30'd0, e.priv});
         end
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      csr_addr = a;
      #1;
      chk(tag, csr_rdata, exp);
   endtask

   task automatic trap(logic irq, logic [4:0] code, logic [31:0] pc,
                       logic [31:0] val, logic also_ret,
                       logic [31:0] epc_exp, logic [1:0] prv_exp, string tag);
      exp_t e;
      @(negedge clk);
      trap_req = 1'b1; trap_irq = irq; trap_code = code;
      trap_pc = pc; trap_val = val;
      ret_req = also_ret; ret_sel_m = 1'b0;
      e.pc = epc_exp; e.priv = prv_exp; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      trap_req = 1'b0; ret_req = 1'b0;
   endtask

   task automatic ret(logic sel_m, logic [31:0] pc_exp, logic [1:0] prv_exp,
                      string tag);
      exp_t e;
      @(negedge clk);
      ret_req = 1'b1; ret_sel_m = sel_m;
      e.pc = pc_exp; e.priv = prv_exp; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      ret_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 priv", {30'd0, cur_priv}, 32'd3);
      chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
      rd(4'd0, 32'd0, "R1 m cause");
      rd(4'd8, 32'd0, "R1 s cause");
      rd(4'd5, 32'd0, "R1 m status");
      rd(4'd6, 32'd0, "R1 ex mask");

      // R11 setup through the CSR map
      wr(4'd4, 32'h0100_0003);
      wr(4'd12, 32'h0200_0001);
      wr(4'd3, 32'hAAAA_5555);
      wr(4'd11, 32'h0000_1234);
      wr(4'd6, 32'h0000_0004);
      wr(4'd7, 32'h0000_0020);
      rd(4'd6, 32'h0000_0004, "R11 ex mask readback");

      // R2: code 2 is delegated, but a trap from machine stays in machine
      trap(1'b0, 5'd2, 32'h80, 32'h11, 1'b0, 32'h0100_0000, 2'd3, "R2 R6 m-from-m");
      rd(4'd0, 32'd2, "R4 m cause");
      rd(4'd1, 32'h80, "R5 m epc");
      rd(4'd2, 32'h11, "R5 m tval");
      rd(4'd8, 32'd0, "R3 s cause untouched");
      rd(4'd5, 32'h0000_000C, "R7 m status");

      // R8 machine return into supervisor
      wr(4'd5, 32'h6);
      wr(4'd1, 32'h400);
      ret(1'b1, 32'h400, 2'd1, "R8 mret");
      rd(4'd5, 32'h3, "R8 m status after ret");

      // R2 delegated exception from supervisor
      trap(1'b0, 5'd2, 32'h404, 32'h22, 1'b0, 32'h0200_0000, 2'd1, "R2 R6 s-deleg exc");
      rd(4'd8, 32'd2, "R3 s cause");
      rd(4'd9, 32'h404, "R5 s epc");
      rd(4'd10, 32'h22, "R5 s tval");
      rd(4'd0, 32'd2, "R3 m cause kept");
      rd(4'd1, 32'h400, "R3 m epc kept");
      rd(4'd2, 32'h11, "R3 m tval kept");
      rd(4'd13, 32'h4, "R7 s status");

      // R2 delegated interrupt
      wr(4'd13, 32'h5);
      trap(1'b1, 5'd5, 32'h500, 32'h0, 1'b0, 32'h0200_0000, 2'd1, "R2 s-deleg irq");
      rd(4'd8, 32'h8000_0005, "R4 s irq cause");
      rd(4'd13, 32'h6, "R7 s status irq");

      // R2 undelegated exception from supervisor goes to machine
      trap(1'b0, 5'd3, 32'h504, 32'h33, 1'b0, 32'h0100_0000, 2'd3, "R2 s-to-m");
      rd(4'd0, 32'd3, "R3 m cause");
      rd(4'd8, 32'h8000_0005, "R3 s cause kept");
      rd(4'd5, 32'h6, "R7 m status from s");

      // R2 delegated interrupt code while in machine stays in machine
      trap(1'b1, 5'd5, 32'h600, 32'h0, 1'b0, 32'h0100_0000, 2'd3, "R2 m-irq stays");
      rd(4'd0, 32'h8000_0005, "R4 m irq cause");
      rd(4'd5, 32'hC, "R7 m status from m");

      // R9 trap and supervisor return together: trap wins
      trap(1'b0, 5'd2, 32'h700, 32'h0, 1'b1, 32'h0100_0000, 2'd3, "R9 trap over ret");
      rd(4'd1, 32'h700, "R9 m epc");
      rd(4'd13, 32'h6, "R9 s status untouched");
      rd(4'd9, 32'h500, "R9 s epc untouched");

      // R8 supervisor return
      ret(1'b0, 32'h500, 2'd1, "R8 sret");
      rd(4'd13, 32'h3, "R8 s status after ret");

      // R2 R4 top mask bit
      wr(4'd6, 32'h8000_0004);
      trap(1'b0, 5'd31, 32'h800, 32'h44, 1'b0, 32'h0200_0000, 2'd1, "R2 code31");
      rd(4'd8, 32'h0000_001F, "R4 code31 cause");

      // R10 scratch untouched by traps and returns
      rd(4'd3, 32'hAAAA_5555, "R10 m scratch");
      rd(4'd11, 32'h0000_1234, "R10 s scratch");

      @(negedge clk);
      chk("R6 scoreboard drained", sb.size(), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule